// File: doc/BRIEF.md
# I2C Clock and Strobe Timing Generator

This block produces the clock waveform of an I2C master together with the points in each clock period where the next data bit is put on the data line and where the incoming data bit is read. A byte-level engine above it issues one request at a time: START, STOP, send one bit, or receive one bit. The block drives the open-drain clock and data enables, returns the sampled data bit, and pulses a completion flag when the request has ended.

Timing comes from three programmable values. The clock divider sets one bus clock period in core clocks. Its least significant bit is ignored, so the divider always acts as an even number. The falling-edge delay sets how many core clocks after the clock goes low the next data bit is launched. The rising-edge delay sets how many core clocks after the clock goes high the data line is sampled. The divider and delay values are written through two simple write ports. They are captured when a request is accepted, so a write made during a request does not disturb it. The clock is timed only by the counter. A slave that holds the clock low is not waited for.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `busy`, `bit_done` and `rx_bit` are all 0.
- R2: The half period H equals the divider with its least significant bit dropped (divider >> 1). For a send, receive or STOP request, cycle 0 is the first cycle after acceptance. `scl_oe` is 1 in cycles 0 to H-1 and 0 in cycles H to 2H-1. `scl_oe` does not depend on `sda_in`.
- R3: An odd divider behaves exactly like the next lower even divider. Divider values 0 and 1 act as 2 (H = 1).
- R4: The delay word carries the falling-edge delay F in bits [2W-1:W] and the rising-edge delay S in bits [W-1:0]. `sda_oe` keeps its previous value before cycle F and holds the new value from cycle F. The new value is `~req_bit` for a send, 0 for a receive and 1 for a STOP.
- R5: For a send or receive, `rx_bit` takes the value of `sda_in` during cycle H+S-1. It shows that value from cycle H+S and holds it until the next sample.
- R6: A delay value of 0 acts as 1, and a delay value larger than H acts as H.
- R7: START (`req_op` = 0) asserts `sda_oe` from cycle 0 through cycle H-1 while `scl_oe` stays 0. The request ends after H cycles and `sda_oe` stays 1 afterwards.
- R8: STOP (`req_op` = 1) drives the clock like a bit (low half, then high half) with SDA pulled low from cycle F. When the request ends after 2H cycles, `sda_oe` returns to 0 while `scl_oe` is 0.
- R9: `busy` is 1 from cycle 0 through the last cycle of a request. `bit_done` is a single-cycle pulse in the cycle after the last cycle. A request presented while `busy` is 1 is ignored. Op codes: 0 START, 1 STOP, 2 send, 3 receive.
- R10: Writes to the divider or delay registers during a request do not change the timing of that request. They take effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 1 | Load the divider register |
| div_wdata | input | DIV_W | Divider value; bit 0 ignored |
| dly_wr | input | 1 | Load the delay register |
| dly_wdata | input | 2*DIV_W | Falling-edge delay in upper half, rising-edge delay in lower half |
| req_valid | input | 1 | Request present (taken when not busy) |
| req_op | input | 2 | 0 START, 1 STOP, 2 send bit, 3 receive bit |
| req_bit | input | 1 | Bit value to send |
| sda_in | input | 1 | Sensed data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_bit | output | 1 | Last sampled data bit |
| bit_done | output | 1 | One-cycle pulse when a request finishes |
| busy | output | 1 | A request is in progress |

## Verification
Each request type is checked cycle by cycle against a trace the bench computes from the divider and the delays. Send is run with both bit values so the launched level is seen to follow the bit. For receives, `sda_in` shows the opposite value in every cycle except the single intended sample cycle, so any sample taken one cycle early or late returns the wrong bit. Odd, tiny and oversized settings (divider 9 and 1, delays 0, 7 and 100) separate correct LSB dropping and clamping from a plain use of the register values. A request and register writes injected mid-request show that the request in progress keeps its timing.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_SEND  = 2'd2,
    OP_RECV  = 2'd3
  } tg_op_e;
endpackage

// File: rtl/scl_tg_cfg.sv
// Divider and delay storage plus clamping to legal effective values.
module scl_tg_cfg #(
  parameter int unsigned            DIV_W   = 16,
  parameter logic [DIV_W-1:0]       DIV_RST = 16'd100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 div_wr,
  input  logic [DIV_W-1:0]     div_wdata,
  input  logic                 dly_wr,
  input  logic [2*DIV_W-1:0]   dly_wdata,
  output logic [DIV_W-2:0]     half_eff,
  output logic [DIV_W-2:0]     fall_eff,
  output logic [DIV_W-2:0]     rise_eff
);
  localparam int unsigned HW = DIV_W - 1;

  logic [HW-1:0]    half_q;
  logic [DIV_W-1:0] fall_q, rise_q;
  logic [HW-1:0]    half_d;
  logic [DIV_W-1:0] fall_d, rise_d;
  logic             unused_div_lsb;

  assign unused_div_lsb = div_wdata[0];

  // next state: divider LSB dropped on entry
  always_comb begin
    half_d = half_q;
    fall_d = fall_q;
    rise_d = rise_q;
    if (div_wr) half_d = div_wdata[DIV_W-1:1];
    if (dly_wr) begin
      fall_d = dly_wdata[2*DIV_W-1:DIV_W];
      rise_d = dly_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= DIV_RST[DIV_W-1:1];
      fall_q <= DIV_W'(1);
      rise_q <= DIV_W'(1);
    end else begin
      half_q <= half_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
    end
  end

  function automatic logic [HW-1:0] clamp_dly(input logic [DIV_W-1:0] v,
                                              input logic [HW-1:0] lim);
    if (v == '0)                clamp_dly = HW'(1);
    else if (v > {1'b0, lim})   clamp_dly = lim;
    else                        clamp_dly = v[HW-1:0];
  endfunction

  always_comb begin
    half_eff = (half_q == '0) ? HW'(1) : half_q;
    fall_eff = clamp_dly(fall_q, half_eff);
    rise_eff = clamp_dly(rise_q, half_eff);
  end

  p_dly_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_eff != '0) && (rise_eff != '0) && (fall_eff <= half_eff) && (rise_eff <= half_eff));

  p_half_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    half_eff != '0);
endmodule

// File: rtl/scl_tg_seq.sv
// Per-request phase counter: clock halves, launch and sample strobes.
module scl_tg_seq
  import scl_tg_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-2:0] half_eff,
  input  logic [DIV_W-2:0] fall_eff,
  input  logic [DIV_W-2:0] rise_eff,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_bit,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             rx_bit,
  output logic             bit_done,
  output logic             busy
);
  localparam int unsigned HW = DIV_W - 1;

  tg_op_e           op_q, op_d;
  logic             bit_q, bit_d;
  logic [HW-1:0]    half_q, half_d, fall_q, fall_d, rise_q, rise_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             busy_d, scl_d, sda_d, rx_d, done_d;

  logic [DIV_W-1:0] half_x, launch_at, rise_at, sample_at, last_at;
  logic             is_bit;

  always_comb begin
    half_x    = {1'b0, half_q};
    launch_at = {1'b0, fall_q} - DIV_W'(1);
    rise_at   = half_x - DIV_W'(1);
    sample_at = half_x + {1'b0, rise_q} - DIV_W'(1);
    last_at   = (op_q == OP_START) ? rise_at : (half_x + half_x - DIV_W'(1));
    is_bit    = (op_q == OP_SEND) || (op_q == OP_RECV);
  end

  // next-state logic
  always_comb begin
    op_d   = op_q;
    bit_d  = bit_q;
    half_d = half_q;
    fall_d = fall_q;
    rise_d = rise_q;
    cnt_d  = cnt_q;
    busy_d = busy;
    scl_d  = scl_oe;
    sda_d  = sda_oe;
    rx_d   = rx_bit;
    done_d = 1'b0;
    if (!busy) begin
      if (req_valid) begin
        op_d   = tg_op_e'(req_op);
        bit_d  = req_bit;
        half_d = half_eff;
        fall_d = fall_eff;
        rise_d = rise_eff;
        cnt_d  = '0;
        busy_d = 1'b1;
        if (tg_op_e'(req_op) == OP_START) sda_d = 1'b1;
        else                              scl_d = 1'b1;
      end
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
      if ((op_q != OP_START) && (cnt_q == launch_at))
        sda_d = (op_q == OP_SEND) ? ~bit_q : (op_q == OP_STOP);
      if ((op_q != OP_START) && (cnt_q == rise_at))
        scl_d = 1'b0;
      if (is_bit && (cnt_q == sample_at))
        rx_d = sda_in;
      if (cnt_q == last_at) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
        if (op_q == OP_STOP) sda_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_START;
      bit_q    <= 1'b0;
      half_q   <= HW'(1);
      fall_q   <= HW'(1);
      rise_q   <= HW'(1);
      cnt_q    <= '0;
      busy     <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_bit   <= 1'b0;
      bit_done <= 1'b0;
    end else begin
      op_q     <= op_d;
      bit_q    <= bit_d;
      half_q   <= half_d;
      fall_q   <= fall_d;
      rise_q   <= rise_d;
      cnt_q    <= cnt_d;
      busy     <= busy_d;
      scl_oe   <= scl_d;
      sda_oe   <= sda_d;
      rx_bit   <= rx_d;
      bit_done <= done_d;
    end
  end

  p_scl_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q != OP_START) && (cnt_q < half_x)) |-> scl_oe);

  p_scl_high_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt_q >= half_x)) |-> !scl_oe);

  p_launch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt_q > {1'b0, fall_q})) |-> $stable(sda_oe));

  p_start_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (op_q == OP_START)) |-> (!scl_oe && sda_oe));

  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_done && $past(op_q == OP_STOP)) |-> (!sda_oe && !scl_oe));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> ($past(busy) && !busy));
endmodule

// File: rtl/i2c_scl_timing_gen.sv
module i2c_scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int unsigned      DIV_W   = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 16'd100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 div_wr,
  input  logic [DIV_W-1:0]     div_wdata,
  input  logic                 dly_wr,
  input  logic [2*DIV_W-1:0]   dly_wdata,
  input  logic                 req_valid,
  input  logic [1:0]           req_op,
  input  logic                 req_bit,
  input  logic                 sda_in,
  output logic                 scl_oe,
  output logic                 sda_oe,
  output logic                 rx_bit,
  output logic                 bit_done,
  output logic                 busy
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-2:0] half_eff, fall_eff, rise_eff;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  scl_tg_cfg #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .div_wr    (div_wr),
    .div_wdata (div_wdata),
    .dly_wr    (dly_wr),
    .dly_wdata (dly_wdata),
    .half_eff  (half_eff),
    .fall_eff  (fall_eff),
    .rise_eff  (rise_eff)
  );

  scl_tg_seq #(.DIV_W(DIV_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .half_eff  (half_eff),
    .fall_eff  (fall_eff),
    .rise_eff  (rise_eff),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_bit   (req_bit),
    .sda_in    (sda_in),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .rx_bit    (rx_bit),
    .bit_done  (bit_done),
    .busy      (busy)
  );
endmodule

// File: tb/test_i2c_scl_timing_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_timing_gen;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           div_wr, dly_wr, req_valid, req_bit, sda_in;
  logic [W-1:0]   div_wdata;
  logic [2*W-1:0] dly_wdata;
  logic [1:0]     req_op;
  logic           scl_oe, sda_oe, rx_bit, bit_done, busy;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model of configuration and line state
  int  m_div, m_fall, m_rise;
  int  m_h, m_f, m_s;
  logic m_sda, m_rx;

  always #5 clk = ~clk;

  i2c_scl_timing_gen i_i2c_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_wdata(div_wdata),
    .dly_wr(dly_wr), .dly_wdata(dly_wdata), .req_valid(req_valid),
    .req_op(req_op), .req_bit(req_bit), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .rx_bit(rx_bit), .bit_done(bit_done), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic derive();
    m_h = m_div / 2;
    if (m_h == 0) m_h = 1;
    m_f = (m_fall == 0) ? 1 : (m_fall > m_h ? m_h : m_fall);
    m_s = (m_rise == 0) ? 1 : (m_rise > m_h ? m_h : m_rise);
  endtask

  task automatic set_cfg(input int dv, input int fl, input int rs);
    @(negedge clk);
    div_wr = 1'b1; div_wdata = W'(dv);
    dly_wr = 1'b1; dly_wdata = {W'(fl), W'(rs)};
    @(negedge clk);
    div_wr = 1'b0; dly_wr = 1'b0;
    m_div = dv; m_fall = fl; m_rise = rs;
    derive();
  endtask

  // op: 0 START, 1 STOP, 2 send, 3 receive
  task automatic run_op(input string req, input int op, input logic b,
                        input logic slave_v, input bit poke);
    int   last;
    logic new_sda, exp_sda, exp_rx;
    last    = (op == 0) ? m_h - 1 : 2 * m_h - 1;
    new_sda = (op == 0) ? 1'b1 : (op == 2) ? ~b : (op == 1) ? 1'b1 : 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_bit = b;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c <= last; c++) begin
      // R2 R7 clock shape
      chk(req, "scl_oe", int'(scl_oe), int'((op != 0) && (c < m_h)));
      // R4 R7 R8 launch point
      exp_sda = (op == 0) ? 1'b1 : (c < m_f ? m_sda : new_sda);
      chk(req, "sda_oe", int'(sda_oe), int'(exp_sda));
      // R5 sample point
      exp_rx = ((op >= 2) && (c >= m_h + m_s)) ? slave_v : m_rx;
      chk(req, "rx_bit", int'(rx_bit), int'(exp_rx));
      chk(req, "busy", int'(busy), 1);
      chk(req, "bit_done", int'(bit_done), 0);
      sda_in = (c == m_h + m_s - 1) ? slave_v : ~slave_v;
      if (poke && c == 0) begin
        // R9 R10: a request and register writes while busy
        req_valid = 1'b1; req_op = 2'd0;
        div_wr = 1'b1; div_wdata = W'(40);
        dly_wr = 1'b1; dly_wdata = {W'(3), W'(3)};
      end else begin
        req_valid = 1'b0; div_wr = 1'b0; dly_wr = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (op >= 2) m_rx = slave_v;
    m_sda = (op == 1) ? 1'b0 : new_sda;
    chk({req, " R9"}, "bit_done", int'(bit_done), 1);
    chk({req, " R9"}, "busy end", int'(busy), 0);
    chk(req, "scl_oe end", int'(scl_oe), 0);
    chk(req, "sda_oe end", int'(sda_oe), int'(m_sda));
    chk(req, "rx_bit end", int'(rx_bit), int'(m_rx));
    @(negedge clk);
    chk({req, " R9"}, "bit_done drop", int'(bit_done), 0);
    chk({req, " R9"}, "idle after", int'(busy), 0);
  endtask

  task automatic t_reset();
    chk("R1", "scl_oe", int'(scl_oe), 0);
    chk("R1", "sda_oe", int'(sda_oe), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "bit_done", int'(bit_done), 0);
    chk("R1", "rx_bit", int'(rx_bit), 0);
  endtask

  task automatic t_frame_even();
    set_cfg(8, 1, 2);
    run_op("R7 start", 0, 1'b0, 1'b0, 1'b0);
    run_op("R2 R4 send1", 2, 1'b1, 1'b1, 1'b0);
    run_op("R2 R4 send0", 2, 1'b0, 1'b0, 1'b0);
    run_op("R5 recv1", 3, 1'b0, 1'b1, 1'b0);
    run_op("R5 recv0", 3, 1'b0, 1'b0, 1'b0);
    run_op("R8 stop", 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_odd_div();
    set_cfg(9, 2, 3);
    run_op("R3 odd start", 0, 1'b0, 1'b0, 1'b0);
    run_op("R3 odd send", 2, 1'b1, 1'b0, 1'b0);
    run_op("R3 odd recv", 3, 1'b0, 1'b1, 1'b0);
    run_op("R3 odd stop", 1, 1'b0, 1'b0, 1'b0);
    set_cfg(1, 1, 2);
    run_op("R3 tiny start", 0, 1'b0, 1'b0, 1'b0);
    run_op("R3 tiny recv", 3, 1'b0, 1'b0, 1'b0);
    run_op("R3 tiny stop", 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_clamp();
    set_cfg(8, 0, 100);
    run_op("R6 start", 0, 1'b0, 1'b0, 1'b0);
    run_op("R6 recv", 3, 1'b0, 1'b1, 1'b0);
    run_op("R6 send", 2, 1'b0, 1'b0, 1'b0);
    set_cfg(8, 7, 0);
    run_op("R6 send late", 2, 1'b1, 1'b1, 1'b0);
    run_op("R6 stop late", 1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_poke();
    set_cfg(12, 2, 2);
    run_op("R10 start", 0, 1'b0, 1'b0, 1'b0);
    run_op("R10 send poked", 2, 1'b1, 1'b1, 1'b1);
    // writes during the request land now: div 40, delays 3/3
    m_div = 40; m_fall = 3; m_rise = 3;
    derive();
    run_op("R10 next uses new", 3, 1'b0, 1'b0, 1'b0);
    run_op("R10 stop", 1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; div_wr = 1'b0; dly_wr = 1'b0; req_valid = 1'b0;
    req_op = 2'd0; req_bit = 1'b0; sda_in = 1'b1;
    div_wdata = '0; dly_wdata = '0;
    m_sda = 1'b0; m_rx = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frame_even();
    t_odd_div();
    t_clamp();
    t_busy_poke();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule